// File: doc/BRIEF.md
# Probabilistic Fill Priority Selector

This block sits beside the install path of a shared cache and chooses, for each line being filled, whether the line enters with a normal replacement state or a vulnerable one. A vulnerable line is the next candidate for eviction. Each requester has its own 4-bit throttle that sets the share of its fills that go in normally. Demand traffic and prefetch traffic from one core count as two separate requesters. The throttles are supplied by an outside adaptation engine. The decision itself is a compare between an effective throttle and a pseudo-random nibble.

To let the adaptation engine measure which way a throttle should move, every cache set is owned by exactly one requester. The owner is found by XOR-folding the set index above bit 0. Bit 0 of the set index splits each owner's sets into a positive half and a negative half. When a requester fills into a set it owns, its throttle is nudged up by a programmable step in the positive half and down by that step in the negative half, with saturation at both ends. Fills into sets owned by other requesters use the throttle as given.

The nudged throttle values for every requester are computed ahead of the fill. The fill itself then only passes through one selection stage and one compare. The random source is a 16-bit maximal-length LFSR that advances once per fill.

Top module: `fill_insert_prio`

## Requirements
- R1: After reset the LFSR state is 16'hACE1 and the skew step is 1. The first fill after reset is decided with random value 4'h1, the low nibble of the seed.
- R2: For a fill into a set owned by a different requester, fill_normal is 1 exactly when rnd < throttle of fill_req. rnd is bits [3:0] of the LFSR state present during that fill.
- R3: For a fill into a set owned by fill_req with set index bit 0 = 1 (positive half), the effective throttle is throttle + step.
- R4: For a fill into a set owned by fill_req with set index bit 0 = 0 (negative half), the effective throttle is throttle - step.
- R5: The effective throttle saturates at 0 and at 15 and never wraps. A throttle of 0 skewed down always yields a vulnerable fill.
- R6: The LFSR advances only in a cycle with fill_valid = 1. Its next state is {state[14:0], state[15]^state[13]^state[12]^state[10]}. Idle cycles leave the random sequence where it was.
- R7: skew_wr = 1 loads skew_wdata into the step register at the clock edge. The new step is used from the next cycle on.
- R8: fill_normal is 0 whenever fill_valid is 0.
- R9: The owner of set index s is the 4-bit value whose bit j is the XOR of s[1+j+4k] over all k with 1+j+4k < SET_W.
- R10: Each requester's decision uses only its own 4-bit throttle field, thr_flat[4r+3:4r].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_valid | input | 1 | A fill is being installed this cycle |
| fill_req | input | 4 | Requester that issued the fill |
| fill_set | input | SET_W (10) | Set index of the fill |
| thr_flat | input | 64 | Throttles of all requesters, 4 bits each, requester r at [4r+3:4r] |
| skew_wr | input | 1 | Load the skew step register |
| skew_wdata | input | 4 | New skew step |
| fill_normal | output | 1 | 1 = normal install, 0 = vulnerable install |

## Verification
The hardest situation to reach from the ports is a fill that lands in the requester's own region while the throttle sits at a saturation edge. It must also arrive just as a particular random nibble comes up. Only then does an off-by-one in the clamp or the strict compare show up. The stimulus builds set indices from the required owner and half, using the fold rule in reverse. It sweeps throttles 0, 1, 14 and 15 against steps from 0 to 15 for long enough that every nibble of the LFSR sequence appears. Idle cycles and step writes are interleaved with fills, so that a sequence advancing at the wrong time or a step taking effect one cycle early would be caught.

// File: rtl/fip_pkg.sv
package fip_pkg;
    localparam int THR_W   = 4;
    localparam int THR_MAX = (1 << THR_W) - 1;

    typedef logic [THR_W-1:0] thr_t;

    function automatic thr_t sat_up(input thr_t base, input thr_t step);
        logic [THR_W:0] sum;
        sum = {1'b0, base} + {1'b0, step};
        return sum[THR_W] ? thr_t'(THR_MAX) : sum[THR_W-1:0];
    endfunction

    function automatic thr_t sat_down(input thr_t base, input thr_t step);
        return (step > base) ? thr_t'(0) : thr_t'(base - step);
    endfunction
endpackage

// File: rtl/fip_lfsr.sv
module fip_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] lfsr_d, lfsr_q;
    logic         fb;

    always_comb begin
        fb     = ^(lfsr_q & TAPS);
        lfsr_d = step ? {lfsr_q[W-2:0], fb} : lfsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;
endmodule

// File: rtl/fip_region_hash.sv
module fip_region_hash #(
    parameter int SET_W = 10,
    parameter int REQ_W = 4
) (
    input  logic [SET_W-1:0] set_idx,
    output logic [REQ_W-1:0] owner,
    output logic             half_pos
);
    localparam int HBITS = SET_W - 1;

    always_comb begin
        owner = '0;
        for (int i = 0; i < HBITS; i++) begin
            owner[i % REQ_W] = owner[i % REQ_W] ^ set_idx[i+1];
        end
        half_pos = set_idx[0];
    end
endmodule

// File: rtl/fip_skew_bank.sv
module fip_skew_bank
    import fip_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input  logic [NUM_REQ*THR_W-1:0] thr_flat,
    input  thr_t                     step,
    output logic [NUM_REQ*THR_W-1:0] up_flat,
    output logic [NUM_REQ*THR_W-1:0] dn_flat
);
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        thr_t base;
        assign base = thr_flat[r*THR_W +: THR_W];
        assign up_flat[r*THR_W +: THR_W] = sat_up(base, step);
        assign dn_flat[r*THR_W +: THR_W] = sat_down(base, step);
    end
endmodule

// File: rtl/fill_insert_prio.sv
module fill_insert_prio
    import fip_pkg::*;
#(
    parameter int             NUM_REQ   = 16,
    parameter int             SET_W     = 10,
    parameter int             LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [THR_W-1:0]  STEP_RST  = 4'd1,
    localparam int            REQ_W     = $clog2(NUM_REQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_valid,
    input  logic [REQ_W-1:0]         fill_req,
    input  logic [SET_W-1:0]         fill_set,
    input  logic [NUM_REQ*THR_W-1:0] thr_flat,
    input  logic                     skew_wr,
    input  logic [THR_W-1:0]         skew_wdata,
    output logic                     fill_normal
);
    typedef struct packed {
        thr_t step;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [LFSR_W-1:0]        lfsr_val;
    logic [REQ_W-1:0]         owner;
    logic                     half_pos;
    logic                     region_hit;
    logic [NUM_REQ*THR_W-1:0] up_flat, dn_flat;
    thr_t                     thr_sel, up_sel, dn_sel, eff_thr, rnd;
    thr_t                     delta_q;

    fip_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fill_valid),
        .state (lfsr_val)
    );

    fip_region_hash #(.SET_W(SET_W), .REQ_W(REQ_W)) u_hash (
        .set_idx  (fill_set),
        .owner    (owner),
        .half_pos (half_pos)
    );

    fip_skew_bank #(.NUM_REQ(NUM_REQ)) u_skew (
        .thr_flat (thr_flat),
        .step     (regs_q.step),
        .up_flat  (up_flat),
        .dn_flat  (dn_flat)
    );

    always_comb begin
        regs_d = regs_q;
        if (skew_wr) regs_d.step = skew_wdata;

        thr_sel    = thr_flat[fill_req*THR_W +: THR_W];
        up_sel     = up_flat[fill_req*THR_W +: THR_W];
        dn_sel     = dn_flat[fill_req*THR_W +: THR_W];
        region_hit = (owner == fill_req);
        rnd        = lfsr_val[THR_W-1:0];
        if (!region_hit)  eff_thr = thr_sel;
        else if (half_pos) eff_thr = up_sel;
        else               eff_thr = dn_sel;
        fill_normal = fill_valid && (rnd < eff_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{step: STEP_RST};
        else        regs_q <= regs_d;
    end

    assign delta_q = regs_q.step;
endmodule

// File: rtl/fip_checker.sv
module fip_checker #(
    parameter int THR_W  = 4,
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_valid,
    input logic              fill_normal,
    input logic              skew_wr,
    input logic [THR_W-1:0]  skew_wdata,
    input logic [THR_W-1:0]  delta_q,
    input logic [LFSR_W-1:0] lfsr_val,
    input logic              region_hit,
    input logic              half_pos,
    input logic [THR_W-1:0]  thr_sel
);
    localparam logic [THR_W:0] TOP = (1 << THR_W) - 1;

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |-> !fill_normal);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> $stable(lfsr_val));

    assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_val != '0);

    assert_step_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        skew_wr |=> delta_q == $past(skew_wdata));

    assert_floor_vuln_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && region_hit && !half_pos && thr_sel <= delta_q) |-> !fill_normal);

    assert_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && region_hit && half_pos &&
         ({1'b0, thr_sel} + {1'b0, delta_q} >= TOP) &&
         lfsr_val[THR_W-1:0] != TOP[THR_W-1:0]) |-> fill_normal);

    assert_zero_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !region_hit && thr_sel == '0) |-> !fill_normal);
endmodule

bind fill_insert_prio fip_checker #(.THR_W(fip_pkg::THR_W), .LFSR_W(LFSR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_valid  (fill_valid),
    .fill_normal (fill_normal),
    .skew_wr     (skew_wr),
    .skew_wdata  (skew_wdata),
    .delta_q     (delta_q),
    .lfsr_val    (lfsr_val),
    .region_hit  (region_hit),
    .half_pos    (half_pos),
    .thr_sel     (thr_sel)
);

// File: tb/fill_insert_prio_bench.sv
`timescale 1ns/1ps
module fill_insert_prio_bench;
    localparam int NREQ  = 16;
    localparam int SETW  = 10;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              fill_valid = 0;
    logic [3:0]        fill_req = '0;
    logic [SETW-1:0]   fill_set = '0;
    logic [NREQ*4-1:0] thr_flat = '0;
    logic              skew_wr = 0;
    logic [3:0]        skew_wdata = '0;
    logic              fill_normal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_lfsr;
    int m_step;
    int thr_m [NREQ];
    bit first_fill;

    always #2.5 clk = ~clk;

    fill_insert_prio u_fill_insert_prio (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_req(fill_req),
        .fill_set(fill_set), .thr_flat(thr_flat), .skew_wr(skew_wr),
        .skew_wdata(skew_wdata), .fill_normal(fill_normal)
    );

    function automatic int owner_of(input int s);
        int o = 0;
        for (int i = 1; i < SETW; i++)
            if ((s >> i) & 1) o = o ^ (1 << ((i - 1) % 4));
        return o;
    endfunction

    function automatic int set_for(input int own, input int pos, input int upper);
        int s = (upper & 31) << 5;
        int rest = owner_of(s);
        return s | (((own ^ rest) & 15) << 1) | (pos & 1);
    endfunction

    task automatic load_thr();
        for (int r = 0; r < NREQ; r++) thr_flat[r*4 +: 4] = 4'(thr_m[r]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One cycle: inputs applied after a rising edge, compared at the falling edge.
    task automatic cyc(input bit v, input int req, input int s, input bit wr, input int wd,
                       input string ph);
        int own, t, eff, rnd;
        bit hit, exp;
        string tag;
        fill_valid = v; fill_req = 4'(req); fill_set = SETW'(s);
        skew_wr = wr; skew_wdata = 4'(wd);
        @(negedge clk);
        own = owner_of(s);
        hit = (own == req);
        t   = thr_m[req];
        if (!hit) eff = t;
        else if (s & 1) eff = (t + m_step > 15) ? 15 : t + m_step;
        else eff = (t < m_step) ? 0 : t - m_step;
        rnd = m_lfsr & 15;
        exp = v && (rnd < eff);
        if (!v) tag = "R8";
        else if (first_fill) tag = "R1";
        else if (hit && ((t + m_step > 15 && (s & 1)) || (t < m_step && !(s & 1)))) tag = "R5";
        else if (hit && (s & 1)) tag = "R3";
        else if (hit) tag = "R4";
        else tag = "R2";
        checks++;
        if (fill_normal !== exp) begin
            fails++;
            $display("FAIL %s (%s) req=%0d set=%0d thr=%0d step=%0d rnd=%0d: got %0b expected %0b",
                     tag, ph, req, s, t, m_step, rnd, fill_normal, exp);
        end
        if (v) begin
            m_lfsr = ((m_lfsr << 1) & 16'hFFFF) |
                     (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
            first_fill = 0;
        end
        if (wr) m_step = wd;
        @(posedge clk); #0.5;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        m_lfsr = 16'hACE1; m_step = 1; first_fill = 1;
        for (int r = 0; r < NREQ; r++) thr_m[r] = r;
        load_thr();
        repeat (3) @(posedge clk);
        // Reset state: output low while held in reset (R8)
        @(negedge clk);
        checks++;
        if (fill_normal !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: got %0b expected 0", fill_normal);
        end
        rst_n = 1;
        @(posedge clk); #0.5;

        // R1: first fill decided from the seed nibble; R2/R10 out-of-region with per-requester throttles
        for (int i = 0; i < 48; i++)
            cyc(1, i % 16, set_for((i + 3) % 16, i & 1, i), 0, 0, "R1_R2_R10");

        // R6: idle cycles between fills keep the sequence in place
        for (int i = 0; i < 40; i++)
            cyc(i % 3 == 0, i % 16, set_for((i + 5) % 16, 0, i * 7), 0, 0, "R6_idle");

        // R3/R4 in-region at default step, all requesters, both halves
        for (int i = 0; i < 64; i++)
            cyc(1, i % 16, set_for(i % 16, (i / 16) & 1, i * 3), 0, 0, "R3_R4_R9");

        // R7 + R5: sweep steps with edge throttles
        thr_m[0] = 0; thr_m[1] = 1; thr_m[2] = 14; thr_m[3] = 15; load_thr();
        for (int st = 0; st < 16; st++) begin
            cyc(0, 0, 0, 1, st, "R7_write");
            for (int i = 0; i < 40; i++)
                cyc(1, i % 4, set_for(i % 4, (i / 4) & 1, i + st), 0, 0, "R5_sweep");
        end

        // R7: write during a fill, new step only from next cycle
        for (int i = 0; i < 32; i++)
            cyc(1, 2, set_for(2, 1, i), (i % 4) == 0, (i * 5) % 16, "R7_fill_wr");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int rq, own;
            if (i % 200 == 0) begin
                for (int r = 0; r < NREQ; r++) thr_m[r] = $urandom_range(0, 15);
                load_thr();
            end
            rq  = $urandom_range(0, 15);
            own = ($urandom_range(0, 1) == 1) ? rq : $urandom_range(0, 15);
            cyc($urandom_range(0, 3) != 0, rq, set_for(own, $urandom_range(0, 1),
                $urandom_range(0, 31)), $urandom_range(0, 15) == 0,
                $urandom_range(0, 15), "R9_R10_mix");
        end
        finish_run();
    end
endmodule